// File: doc/BRIEF.md
# Stream Receive Frame Acceptance Filter

This block sits between a receive MAC and a stream decoder. At the start of each incoming frame it is given the header fields: destination address, source address and type field. It compares them with a set of configuration inputs and decides whether the frame's payload goes on to the decoder. One cycle after the header strobe it raises either an accept pulse or a drop pulse. The decision holds until the payload word flagged as last has been consumed.

Payload words arrive on a valid/ready stream and leave on a second valid/ready stream. In an accepted frame, words pass through without any register stage, and the downstream ready is returned upstream unchanged. In a dropped frame, and outside any frame, words are consumed (ready held high) and never presented downstream. If a non-zero word limit is configured, only that many payload words of an accepted frame are forwarded. The last of them carries the last flag, and the remainder of the frame is consumed silently. Words are a multiple of 16 bits wide, 32 by default.

Top module: `rx_frame_filter`

## Requirements
- R1: A frame whose type field differs from `cfg_ethertype` (reset value of the configuration 16'hDBFF at system level) is dropped whatever its addresses are.
- R2: A frame whose destination is all ones (48'hFFFF_FFFF_FFFF) passes the destination test exactly when `cfg_bcast_en` is 1.
- R3: A frame with any other destination passes the destination test when that destination equals `cfg_local_mac`, or when `cfg_local_mac` is all zeros.
- R4: When `cfg_src_filter` is 1, a frame is accepted only if `hdr_src` equals `cfg_remote_mac`. When it is 0, the source is not examined.
- R5: In the cycle after each `hdr_valid` cycle, exactly one of `accept_p` and `drop_p` is high for one cycle: `accept_p` when R1 to R4 all pass, `drop_p` otherwise. Neither pulses in any other cycle.
- R6: In an accepted frame, each input word appears on `out_data` unchanged in the same cycle, with `out_valid = in_valid` and `in_ready = out_ready`. A stall from downstream therefore holds the word upstream.
- R7: In a dropped frame, `out_valid` stays 0 and `in_ready` stays 1.
- R8: With `cfg_word_limit` = N > 0, exactly the first N words of an accepted frame are forwarded, and the N-th carries `out_last`. Later words of the frame are consumed with `out_valid` 0.
- R9: With `cfg_word_limit` = 0, every word of an accepted frame is forwarded, and `out_last` follows `in_last`. A frame that ends before N words under R8 also ends with `out_last` from `in_last`.
- R10: After reset, no frame is active: `accept_p`, `drop_p` and `out_valid` are 0. Words arriving with no frame active, including after a frame's last word, are consumed and not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_local_mac | input | 48 | Own address; all zeros accepts any unicast destination |
| cfg_remote_mac | input | 48 | Permitted source when source filtering is on |
| cfg_ethertype | input | 16 | Expected type field |
| cfg_bcast_en | input | 1 | 1: broadcast destinations pass |
| cfg_src_filter | input | 1 | 1: source must equal cfg_remote_mac |
| cfg_word_limit | input | LIMIT_W | Payload words forwarded per frame; 0 means no limit |
| hdr_valid | input | 1 | One-cycle strobe: header fields valid, new frame begins |
| hdr_dst | input | 48 | Destination address |
| hdr_src | input | 48 | Source address |
| hdr_type | input | 16 | Type field |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word consumed |
| in_data | input | WORD_W | Payload word |
| in_last | input | 1 | Final word of the frame |
| out_valid | output | 1 | Forwarded word valid |
| out_ready | input | 1 | Decoder can take a word |
| out_data | output | WORD_W | Forwarded word |
| out_last | output | 1 | Final forwarded word of the frame |
| accept_p | output | 1 | Pulse: frame accepted |
| drop_p | output | 1 | Pulse: frame dropped |

## Verification
The accept/drop pulse is due exactly one clock after the `hdr_valid` cycle. The bench raises the strobe after a falling edge, lowers it at the next falling edge, and samples the pulses there. The first payload word may be presented at that same point. The payload path has no register stage, so `out_valid`, `out_data`, `out_last` and `in_ready` are due in the cycle the word is driven. The bench samples them one time unit after driving, well before the rising edge. The word count advances on the rising edge that completes a handshake, and the bench's model updates its own count at the same point.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef logic [47:0] mac_t;
  localparam mac_t MAC_ALL_ONES = '1;
  localparam mac_t MAC_ZERO     = '0;

  function automatic logic is_group_all(input mac_t a);
    return a == MAC_ALL_ONES;
  endfunction
endpackage

// File: rtl/rxf_hdr_match.sv
module rxf_hdr_match
  import rxf_pkg::*;
(
  input  mac_t        local_mac,
  input  mac_t        remote_mac,
  input  logic [15:0] want_type,
  input  logic        bcast_en,
  input  logic        src_filter,
  input  mac_t        dst,
  input  mac_t        src,
  input  logic [15:0] etype,
  output logic        pass
);
  logic type_ok, dst_ok, src_ok, bcast;

  always_comb begin
    bcast   = is_group_all(dst);
    type_ok = (etype == want_type);
    if (bcast) dst_ok = bcast_en;
    else       dst_ok = (local_mac == MAC_ZERO) || (dst == local_mac);
    src_ok  = !src_filter || (src == remote_mac);
    pass    = type_ok && dst_ok && src_ok;
  end
endmodule

// File: rtl/rxf_word_gate.sv
module rxf_word_gate #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               active,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               out_ready,
  output logic               in_ready,
  output logic               out_valid,
  output logic               out_last,
  output logic               fire_in
);
  logic [LIMIT_W-1:0] cnt;
  logic limited, capped, fwd_en;

  always_comb begin
    limited   = (limit != '0);
    capped    = limited && (cnt >= limit);
    fwd_en    = active && !capped;
    out_valid = in_valid && fwd_en;
    in_ready  = fwd_en ? out_ready : 1'b1;
    out_last  = in_last || (limited && (cnt == limit - 1'b1));
    fire_in   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (start)                      cnt <= '0;
    else if (out_valid && out_ready)     cnt <= cnt + 1'b1;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  limit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limited && !start && $past(limit) == limit && cnt == limit) |-> !out_valid);
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [47:0]        cfg_local_mac,
  input  logic [47:0]        cfg_remote_mac,
  input  logic [15:0]        cfg_ethertype,
  input  logic               cfg_bcast_en,
  input  logic               cfg_src_filter,
  input  logic [LIMIT_W-1:0] cfg_word_limit,
  input  logic               hdr_valid,
  input  logic [47:0]        hdr_dst,
  input  logic [47:0]        hdr_src,
  input  logic [15:0]        hdr_type,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last,
  output logic               accept_p,
  output logic               drop_p
);
  localparam int HALVES = WORD_W / 16;

  logic pass, active, fire_in;

  rxf_hdr_match u_match (
    .local_mac (cfg_local_mac),
    .remote_mac(cfg_remote_mac),
    .want_type (cfg_ethertype),
    .bcast_en  (cfg_bcast_en),
    .src_filter(cfg_src_filter),
    .dst       (hdr_dst),
    .src       (hdr_src),
    .etype     (hdr_type),
    .pass      (pass)
  );

  rxf_word_gate #(.LIMIT_W(LIMIT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hdr_valid),
    .active   (active),
    .limit    (cfg_word_limit),
    .in_valid (in_valid),
    .in_last  (in_last),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_last (out_last),
    .fire_in  (fire_in)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      accept_p <= 1'b0;
      drop_p   <= 1'b0;
    end else begin
      accept_p <= hdr_valid && pass;
      drop_p   <= hdr_valid && !pass;
      if (hdr_valid)                active <= pass;
      else if (fire_in && in_last)  active <= 1'b0;
    end
  end

  assign out_data = in_data;

  initial begin
    width_chk: assert (HALVES * 16 == WORD_W && HALVES > 0);
  end

  // R5
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (accept_p != drop_p));

  // R5
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> (!accept_p && !drop_p));

  // R7
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_p |-> (!out_valid && in_ready));

  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_last && !hdr_valid) |=> !out_valid);
endmodule

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  localparam int CLK_NS = 10;
  localparam logic [15:0] ET = 16'hDBFF;
  localparam logic [47:0] MA = 48'h0011_2233_4455;
  localparam logic [47:0] MB = 48'h0066_7788_99AA;
  localparam logic [47:0] RR = 48'h00AB_CDEF_0102;
  localparam logic [47:0] SS = 48'h0012_3456_789A;

  logic clk = 0, rst_n = 0;
  logic [47:0] cfg_local_mac = MA, cfg_remote_mac = RR;
  logic [15:0] cfg_ethertype = ET;
  logic cfg_bcast_en = 1, cfg_src_filter = 0;
  logic [15:0] cfg_word_limit = 0;
  logic hdr_valid = 0;
  logic [47:0] hdr_dst = 0, hdr_src = 0;
  logic [15:0] hdr_type = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [31:0] in_data = 0;
  logic in_ready, out_valid, out_last, accept_p, drop_p;
  logic [31:0] out_data;

  int errors = 0, checks = 0;
  logic exp_act = 0;
  int cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  rx_frame_filter uut (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model(input logic [47:0] d, s, input logic [15:0] t);
    logic dok;
    if (d == '1) dok = cfg_bcast_en;
    else dok = (cfg_local_mac == 0) || (d == cfg_local_mac);
    return (t == cfg_ethertype) && dok && (!cfg_src_filter || s == cfg_remote_mac);
  endfunction

  task automatic header(input logic [47:0] d, s, input logic [15:0] t);
    logic e;
    hdr_valid = 1; hdr_dst = d; hdr_src = s; hdr_type = t;
    e = model(d, s, t);
    @(negedge clk);
    hdr_valid = 0;
    // R1 R2 R3 R4 R5
    chk(accept_p == e && drop_p == !e, "R5 verdict (R1 R2 R3 R4)", {accept_p, drop_p}, {e, !e});
    exp_act = e; cnt = 0;
  endtask

  task automatic word(input logic [31:0] d, input logic last);
    logic fwd, el;
    int lim;
    lim = cfg_word_limit;
    fwd = exp_act && (lim == 0 || cnt < lim);
    el  = last || (lim != 0 && cnt == lim - 1);
    in_valid = 1; in_data = d; in_last = last;
    #1;
    // R6 R7 R8 R10
    chk(out_valid == fwd, "R7 R8 R10 out_valid", out_valid, fwd);
    chk(in_ready == (fwd ? out_ready : 1'b1), "R6 R7 in_ready", in_ready, fwd ? out_ready : 1'b1);
    if (fwd) begin
      // R6 R9
      chk(out_data == d && out_last == el, "R6 R9 data/last", {out_last, out_data}, {el, d});
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    if (!fwd || out_ready) begin
      if (fwd) cnt++;
      if (last) exp_act = 0;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] dl [3];
    logic [47:0] sl [2];
    dl[0] = MA; dl[1] = MB; dl[2] = '1;
    sl[0] = RR; sl[1] = SS;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!accept_p && !drop_p && !out_valid, "R10 reset", {accept_p, drop_p, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    word(32'hDEAD0001, 1'b1); // R10 idle word
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int l = 0; l < 2; l++)
          for (int di = 0; di < 3; di++)
            for (int si = 0; si < 2; si++)
              for (int ti = 0; ti < 2; ti++) begin
                cfg_bcast_en = b[0]; cfg_src_filter = f[0];
                cfg_local_mac = l[0] ? 48'h0 : MA;
                header(dl[di], sl[si], ti[0] ? 16'h0800 : ET);
                for (int w = 0; w < 3; w++) word(32'h1000 * di + w + 64 * ti, w == 2);
                word(32'hBEEF, 1'b0); // R10 after last
              end
    cfg_bcast_en = 1; cfg_src_filter = 0; cfg_local_mac = MA;
    // R8 limit 2 of 5
    cfg_word_limit = 2;
    header(MA, SS, ET);
    for (int w = 0; w < 5; w++) word(32'hA0 + w, w == 4);
    // R9 limit 5, frame of 3
    cfg_word_limit = 5;
    header(MA, SS, ET);
    for (int w = 0; w < 3; w++) word(32'hB0 + w, w == 2);
    word(32'hB9, 1'b0);
    // R6 back-pressure
    cfg_word_limit = 0;
    header('1, SS, ET);
    out_ready = 0;
    word(32'hC0, 1'b0);
    word(32'hC0, 1'b0);
    out_ready = 1;
    word(32'hC0, 1'b0);
    word(32'hC1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule